// File: doc/BRIEF.md
# Toggle Bit Completion Poller

This block sits on the host side of a flash device. It finds out whether a program or erase that is already running has finished. It reads the device status byte over a request/response bus and compares a chosen toggle bit between two reads in a row. If the bit holds steady, the operation is over. If the bit keeps changing, the block looks at the timeout flag in bit 5 of the second read. A low flag means it polls again with a fresh pair of reads. A high flag starts one extra confirming pair of reads. Steady toggling on that confirming pair gives success. Continued toggling gives failure, and the block then writes a reset command to the device.

A pulse on `start` begins a poll. The result stays on `done`, `fail`, `hang` and `status` until the next poll. A programmable ceiling on pairs that toggle with the timeout flag low ends a run that never settles. That case is reported as `hang` and is kept apart from a device failure. The host may `abort` a poll to do other work. The block then lets the read already in flight finish, discards its data and returns to idle. A later poll always begins again from a new initial pair of reads.

The request channel follows valid/ready rules. Once `req_valid` rises, the block holds it high, with address, direction and write data unchanged, until the cycle in which `req_ready` is high. Writes complete at that handshake. Reads return exactly one `rsp_valid` beat later. The response channel has no ready, because the block is always waiting for a response while a read is outstanding. At most one read is outstanding at any time.

Top module: `tgl_poll_ctrl`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `fail`, `hang` and `req_valid` are all low.
- R2: A poll issues reads to `poll_addr`. It ends with `done` high and `fail` and `hang` low when the selected toggle bit is equal in both reads of a pair. `status` then holds the second read's byte.
- R3: With `tbit_sel` low the toggle bit is bit 6 of the status byte; with `tbit_sel` high it is bit 2. The selection is sampled at `start`.
- R4: When the toggle bit differs within a pair and bit 5 of the pair's second read is 0, a new pair of reads follows.
- R5: When the toggle bit differs and bit 5 of the second read is 1, one confirming pair is read. An equal toggle bit across the confirming pair ends the poll as success.
- R6: If the confirming pair still toggles, exactly one write of `RST_DATA` to `RST_ADDR` is issued. After that write is accepted, `done` and `fail` go high.
- R7: With `iter_lim` = L, where L is not 0, the poll ends with `done` and `hang` high, `fail` low and no write after L pairs that toggled with bit 5 at 0. With L = 0 there is no ceiling.
- R8: `abort` during a poll lets the outstanding read finish and discards it. The block then returns to idle without `done`, and the next poll starts with a brand-new pair of reads.
- R9: While `req_valid` is high and `req_ready` is low, the request and its payload stay unchanged in the next cycle.
- R10: `start` is ignored while `busy` is high. `done`, `fail`, `hang` and `status` hold their values until the next accepted `start`.
- R11: `busy` is high from the cycle after an accepted `start` until the poll ends, and it is never high at the same time as `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse that begins a poll (idle or done only) |
| abort | input | 1 | Abandon the current poll |
| tbit_sel | input | 1 | 0: toggle bit is bit 6, 1: toggle bit is bit 2 |
| iter_lim | input | ITW | Ceiling on toggling pairs with bit 5 low, 0 = none |
| poll_addr | input | AW | Address the status reads go to |
| req_valid | output | 1 | Request valid |
| req_ready | input | 1 | Request accepted this cycle |
| req_write | output | 1 | 1 = reset command write, 0 = status read |
| req_addr | output | AW | Request address |
| req_wdata | output | DW | Write data |
| rsp_valid | input | 1 | Read data valid |
| rsp_data | input | DW | Read data |
| busy | output | 1 | Poll in progress |
| done | output | 1 | Poll ended |
| fail | output | 1 | Ended with device failure |
| hang | output | 1 | Ended at iteration ceiling |
| status | output | DW | Last status byte of the pair that decided the result |

## Verification
The bench builds the block with AW = 12, DW = 8 and ITW = 4. With these widths the iteration ceiling can be set as low as one pair, so reaching the ceiling costs only a few dozen cycles. That lets the bench sweep the point where toggling stops, the read at which bit 5 rises, the ceiling and the toggle bit selection together. Each of these sweeps finishes in a few thousand cycles. A bench device model with back-pressure on ready produces the statuses. The expected read count, result and final byte are worked out from the pair arithmetic.

// File: rtl/tgl_poll_pkg.sv
package tgl_poll_pkg;
  typedef enum logic [2:0] {
    PS_IDLE = 3'd0,
    PS_REQ  = 3'd1,
    PS_WAIT = 3'd2,
    PS_RST  = 3'd3,
    PS_FIN  = 3'd4
  } poll_st_e;
endpackage

// File: rtl/tgl_iter_ctr.sv
module tgl_iter_ctr #(
  parameter int ITW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           inc,
  input  logic [ITW-1:0] lim,
  output logic           at_lim
);
  localparam int CW = ITW + 1;
  logic [ITW-1:0] cnt_q;
  logic [CW-1:0]  nxt;

  assign nxt    = {1'b0, cnt_q} + CW'(1);
  assign at_lim = (lim != '0) && (nxt == {1'b0, lim});

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt_q <= '0;
    else if (inc)      cnt_q <= cnt_q + ITW'(1);
  end
endmodule

// File: rtl/tgl_cmp.sv
module tgl_cmp (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic bit_in,
  output logic same
);
  logic first_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    first_q <= 1'b0;
    else if (load) first_q <= bit_in;
  end

  assign same = (first_q == bit_in);
endmodule

// File: rtl/tgl_req_fmt.sv
module tgl_req_fmt #(
  parameter int AW       = 12,
  parameter int DW       = 8,
  parameter int RST_ADDR = 'h555,
  parameter int RST_DATA = 'hF0
) (
  input  logic          is_wr,
  input  logic [AW-1:0] rd_addr,
  output logic          write,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] wdata
);
  localparam logic [AW-1:0] CMD_A = AW'(RST_ADDR);
  localparam logic [DW-1:0] CMD_D = DW'(RST_DATA);

  always_comb begin
    write = is_wr;
    addr  = is_wr ? CMD_A : rd_addr;
    wdata = is_wr ? CMD_D : '0;
  end
endmodule

// File: rtl/tgl_poll_ctrl.sv
module tgl_poll_ctrl #(
  parameter int AW       = 12,
  parameter int DW       = 8,
  parameter int ITW      = 4,
  parameter int TGL_A    = 6,
  parameter int TGL_B    = 2,
  parameter int TO_BIT   = 5,
  parameter int RST_ADDR = 'h555,
  parameter int RST_DATA = 'hF0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           abort,
  input  logic           tbit_sel,
  input  logic [ITW-1:0] iter_lim,
  input  logic [AW-1:0]  poll_addr,
  output logic           req_valid,
  input  logic           req_ready,
  output logic           req_write,
  output logic [AW-1:0]  req_addr,
  output logic [DW-1:0]  req_wdata,
  input  logic           rsp_valid,
  input  logic [DW-1:0]  rsp_data,
  output logic           busy,
  output logic           done,
  output logic           fail,
  output logic           hang,
  output logic [DW-1:0]  status
);
  import tgl_poll_pkg::*;

  poll_st_e       st_q;
  logic           second_q, confirm_q, abt_q, fail_q, hang_q, sel_q;
  logic [ITW-1:0] lim_q;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  stat_q;

  logic go, got, tbit, tobit, same, at_lim, cnt_inc, cmp_load;

  assign go    = start && (st_q == PS_IDLE || st_q == PS_FIN);
  assign got   = (st_q == PS_WAIT) && rsp_valid;
  assign tbit  = sel_q ? rsp_data[TGL_B] : rsp_data[TGL_A];
  assign tobit = rsp_data[TO_BIT];

  assign cmp_load = got && !second_q;
  assign cnt_inc  = got && second_q && !confirm_q && !(abt_q || abort)
                    && !same && !tobit && !at_lim;

  tgl_cmp u_cmp (
    .clk(clk), .rst_n(rst_n), .load(cmp_load), .bit_in(tbit), .same(same)
  );

  tgl_iter_ctr #(.ITW(ITW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .clr(go), .inc(cnt_inc), .lim(lim_q), .at_lim(at_lim)
  );

  tgl_req_fmt #(.AW(AW), .DW(DW), .RST_ADDR(RST_ADDR), .RST_DATA(RST_DATA)) u_fmt (
    .is_wr(st_q == PS_RST), .rd_addr(addr_q),
    .write(req_write), .addr(req_addr), .wdata(req_wdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= PS_IDLE;
      second_q  <= 1'b0;
      confirm_q <= 1'b0;
      abt_q     <= 1'b0;
      fail_q    <= 1'b0;
      hang_q    <= 1'b0;
      sel_q     <= 1'b0;
      lim_q     <= '0;
      addr_q    <= '0;
      stat_q    <= '0;
    end else if (go) begin
      st_q      <= PS_REQ;
      second_q  <= 1'b0;
      confirm_q <= 1'b0;
      abt_q     <= 1'b0;
      fail_q    <= 1'b0;
      hang_q    <= 1'b0;
      sel_q     <= tbit_sel;
      lim_q     <= iter_lim;
      addr_q    <= poll_addr;
    end else begin
      case (st_q)
        PS_REQ: begin
          if (abort) abt_q <= 1'b1;
          if (req_ready) st_q <= PS_WAIT;
        end
        PS_WAIT: begin
          if (rsp_valid) begin
            if (abt_q || abort) begin
              abt_q    <= 1'b0;
              second_q <= 1'b0;
              st_q     <= PS_IDLE;
            end else if (!second_q) begin
              second_q <= 1'b1;
              st_q     <= PS_REQ;
            end else begin
              second_q <= 1'b0;
              stat_q   <= rsp_data;
              if (same) begin
                st_q <= PS_FIN;
              end else if (confirm_q) begin
                fail_q <= 1'b1;
                st_q   <= PS_RST;
              end else if (tobit) begin
                confirm_q <= 1'b1;
                st_q      <= PS_REQ;
              end else if (at_lim) begin
                hang_q <= 1'b1;
                st_q   <= PS_FIN;
              end else begin
                st_q <= PS_REQ;
              end
            end
          end else if (abort) begin
            abt_q <= 1'b1;
          end
        end
        PS_RST: begin
          if (req_ready) st_q <= PS_FIN;
        end
        default: ;
      endcase
    end
  end

  assign req_valid = (st_q == PS_REQ) || (st_q == PS_RST);
  assign busy      = (st_q == PS_REQ) || (st_q == PS_WAIT) || (st_q == PS_RST);
  assign done      = (st_q == PS_FIN);
  assign fail      = done && fail_q;
  assign hang      = done && hang_q;
  assign status    = stat_q;
endmodule

// File: rtl/tgl_poll_ctrl_chk.sv
module tgl_poll_ctrl_chk #(
  parameter int AW       = 12,
  parameter int DW       = 8,
  parameter int RST_ADDR = 'h555,
  parameter int RST_DATA = 'hF0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_write,
  input logic [AW-1:0] req_addr,
  input logic [DW-1:0] req_wdata,
  input logic          busy,
  input logic          done,
  input logic          fail,
  input logic          hang,
  input logic [DW-1:0] status
);
  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr)
                                 && $stable(req_write) && $stable(req_wdata));

  // R11
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R7
  hang_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hang || fail) |-> done && !(hang && fail));

  // R6
  wr_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write |-> req_addr == AW'(RST_ADDR) && req_wdata == DW'(RST_DATA));

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(status) && $stable(fail) && $stable(hang));

  // R1
  idle_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid);
endmodule

bind tgl_poll_ctrl tgl_poll_ctrl_chk #(
  .AW(AW), .DW(DW), .RST_ADDR(RST_ADDR), .RST_DATA(RST_DATA)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start),
  .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
  .req_addr(req_addr), .req_wdata(req_wdata),
  .busy(busy), .done(done), .fail(fail), .hang(hang), .status(status)
);

// File: tb/tgl_poll_ctrl_tb.sv
module tgl_poll_ctrl_tb;
  localparam int CLK_NS = 10;
  localparam int AW = 12;
  localparam int DW = 8;
  localparam int ITW = 4;
  localparam logic [AW-1:0] CMD_A = 12'h555;
  localparam logic [DW-1:0] CMD_D = 8'hF0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, abort = 1'b0, tbit_sel = 1'b0;
  logic [ITW-1:0] iter_lim = '0;
  logic [AW-1:0] poll_addr = 12'h2A0;
  logic req_valid, req_write, req_ready;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic rsp_valid;
  logic [DW-1:0] rsp_data;
  logic busy, done, fail, hang;
  logic [DW-1:0] status;

  int checks = 0, errors = 0;
  int reads_served = 0, writes_seen = 0, rdy_ph = 0;
  logic [AW-1:0] wr_addr_seen = '0, rd_addr_seen = '0;
  logic [DW-1:0] wr_data_seen = '0;
  logic pend = 1'b0;
  logic [DW-1:0] pend_data = '0;

  int dev_n = 0, dev_m = 0, dev_base = 0;
  bit dev_b2_fixed = 1'b0;
  logic [DW-1:0] dev_d = 8'hC4;

  always #(CLK_NS/2) clk = ~clk;

  tgl_poll_ctrl #(.AW(AW), .DW(DW), .ITW(ITW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .tbit_sel(tbit_sel),
    .iter_lim(iter_lim), .poll_addr(poll_addr), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .busy(busy), .done(done), .fail(fail), .hang(hang), .status(status)
  );

  // device status for relative read k (1-based)
  function automatic logic [DW-1:0] rel_byte(input int k);
    logic [DW-1:0] b;
    b = '0;
    if (k <= dev_n) begin
      b[6] = k[0];
      b[2] = dev_b2_fixed ? 1'b0 : k[0];
      b[5] = (dev_m != 0) && (k >= dev_m);
      b[0] = k[1];
    end else begin
      b = dev_d;
    end
    return b;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      req_ready <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      pend      <= 1'b0;
    end else begin
      rdy_ph    <= rdy_ph + 1;
      req_ready <= (rdy_ph % 3) != 2;
      rsp_valid <= 1'b0;
      if (pend) begin
        rsp_valid <= 1'b1;
        rsp_data  <= pend_data;
        pend      <= 1'b0;
      end
      if (req_valid && req_ready) begin
        if (req_write) begin
          writes_seen  <= writes_seen + 1;
          wr_addr_seen <= req_addr;
          wr_data_seen <= req_wdata;
        end else begin
          reads_served <= reads_served + 1;
          rd_addr_seen <= req_addr;
          pend         <= 1'b1;
          pend_data    <= rel_byte(reads_served + 1 - dev_base);
        end
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_done();
    for (int g = 0; g < 4000 && !done; g++) @(negedge clk);
  endtask

  // outcome: 0 ok, 1 fail, 2 hang
  task automatic run_poll(input string req, input logic sel, input int lim,
                          input int poke, input int exp_out, input int exp_rd,
                          input logic [DW-1:0] exp_st);
    int rd0, wr0;
    rd0 = reads_served;
    wr0 = writes_seen;
    dev_base = reads_served;
    @(negedge clk);
    start = 1'b1; tbit_sel = sel; iter_lim = ITW'(lim);
    @(negedge clk);
    start = 1'b0;
    check("R11 busy after start", int'(busy), 1);
    if (poke > 0) begin
      repeat (poke) @(negedge clk);
      start = 1'b1; tbit_sel = ~sel; iter_lim = '0;
      @(negedge clk);
      start = 1'b0;
    end
    wait_done();
    check({req, " done"}, int'(done), 1);
    check({req, " fail"}, int'(fail), exp_out == 1 ? 1 : 0);
    check({req, " hang"}, int'(hang), exp_out == 2 ? 1 : 0);
    check({req, " reads"}, reads_served - rd0, exp_rd);
    check({req, " status"}, int'(status), int'(exp_st));
    check({req, " writes"}, writes_seen - wr0, exp_out == 1 ? 1 : 0);
    if (exp_out == 1) begin
      check("R6 cmd addr", int'(wr_addr_seen), int'(CMD_A));
      check("R6 cmd data", int'(wr_data_seen), int'(CMD_D));
    end
    check("R2 read addr", int'(rd_addr_seen), int'(poll_addr));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lims[5];
    int p, q, r0;
    lims = '{0, 1, 2, 3, 7};
    repeat (3) @(negedge clk);
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 req_valid", int'(req_valid), 0);
    check("R1 fail/hang", int'(fail | hang), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", int'(busy | done | req_valid), 0);

    // R2 R3 R4 R7: toggling stops after n reads; ceiling sweep
    for (int n = 0; n < 10; n++) begin
      for (int li = 0; li < 5; li++) begin
        for (int s = 0; s < 2; s++) begin
          dev_n = n; dev_m = 0; dev_b2_fixed = 1'b0; dev_d = 8'hC4;
          p = n / 2 + 1;
          if (lims[li] != 0 && lims[li] <= p - 1)
            run_poll("R7 ceiling", s[0], lims[li], 0, 2, 2 * lims[li], rel_byte(2 * lims[li]));
          else
            run_poll("R4 R2 settle", s[0], lims[li], 0, 0, 2 * p, 8'hC4);
        end
      end
    end

    // R5 R6: stuck device, timeout bit from read m
    for (int m = 1; m <= 6; m++) begin
      for (int li = 0; li < 3; li += 2) begin
        dev_n = 1000; dev_m = m; dev_b2_fixed = 1'b0;
        q = (m + 1) / 2;
        if (lims[li] != 0 && lims[li] <= q - 1)
          run_poll("R7 ceiling before timeout", 1'b0, lims[li], 0, 2, 2 * lims[li], rel_byte(2 * lims[li]));
        else
          run_poll("R6 confirm fails", 1'b0, lims[li], 0, 1, 2 * q + 2, rel_byte(2 * q + 2));
      end
    end

    // R5: toggling stops exactly as timeout bit rises
    for (int n = 2; n <= 8; n += 2) begin
      dev_n = n; dev_m = n; dev_b2_fixed = 1'b0; dev_d = 8'hC4;
      run_poll("R5 confirm ok", 1'b1, 0, 0, 0, n + 2, 8'hC4);
    end

    // R3: bit 2 fixed while bit 6 toggles
    dev_n = 1000; dev_m = 0; dev_b2_fixed = 1'b1;
    run_poll("R3 select bit2", 1'b1, 0, 0, 0, 2, rel_byte(2));
    run_poll("R3 select bit6", 1'b0, 3, 0, 2, 6, rel_byte(6));

    // R10: start during busy ignored
    dev_n = 9; dev_m = 0; dev_b2_fixed = 1'b0; dev_d = 8'hC4;
    run_poll("R10 start ignored", 1'b0, 0, 7, 0, 10, 8'hC4);
    repeat (5) @(negedge clk);
    check("R10 done held", int'(done), 1);
    check("R10 status held", int'(status), 'hC4);

    // R8: abort after first read, then restart from a fresh pair
    dev_n = 1000; dev_m = 0; dev_base = reads_served;
    r0 = reads_served;
    @(negedge clk);
    start = 1'b1; tbit_sel = 1'b0; iter_lim = '0;
    @(negedge clk);
    start = 1'b0;
    for (int g = 0; g < 200 && reads_served == r0; g++) @(negedge clk);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    for (int g = 0; g < 200 && busy; g++) @(negedge clk);
    check("R8 idle after abort", int'(busy), 0);
    check("R8 no done after abort", int'(done), 0);
    check("R8 reads before idle", reads_served - r0 <= 2 ? 1 : 0, 1);
    dev_n = 0; dev_d = 8'h80;
    run_poll("R8 restart", 1'b0, 0, 0, 0, 2, 8'h80);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule